// File: doc/BRIEF.md
# Two-wire bus start/stop condition qualifier

This block monitors the clock line (SCL) and data line (SDA) of a two-wire serial bus and reports when a bus master opens or closes a transfer. An opening condition is SDA falling while SCL is high. A closing condition is SDA rising while SCL is high. Both lines first pass through a two-flop synchronizer. They are then sampled on a sampling tick. That tick fires on every clock cycle or on every second clock cycle, and a select input chooses which.

An SDA edge is accepted only when it passes a timing check. SDA must hold its old level, with SCL high, for at least `THRESH` sampling ticks before the edge. It must then hold its new level, with SCL high, for at least `THRESH` ticks counted from the edge tick. Edges that fail the check are dropped.

Both conditions drive the same one-cycle interrupt pulse. A busy flag records which condition caused the pulse: it is set by an opening condition and cleared by a closing one, so software reads it to learn the cause.

Top module: `bus_cond_detector`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, `irq_pulse` and `bus_busy` are 0.
- R2: An SDA fall with SCL high is accepted as an opening condition when both the setup and hold windows are at least `THRESH` (default 4) sampling ticks long. Acceptance pulses `irq_pulse` once and sets `bus_busy` to 1. An opening condition accepted while the bus is already busy also pulses and leaves `bus_busy` at 1.
- R3: An SDA rise with SCL high that meets the same windows is a closing condition. It pulses `irq_pulse` once and clears `bus_busy` to 0.
- R4: If SDA was stable with SCL high for fewer than `THRESH` ticks before its edge, the edge is ignored. There is no pulse and `bus_busy` keeps its value.
- R5: If SDA or SCL changes within `THRESH` ticks of the edge tick, the edge tick included, the edge is ignored. There is no pulse and `bus_busy` keeps its value.
- R6: SDA changes while SCL is low never produce a pulse or change `bus_busy`.
- R7: `irq_pulse` is high for exactly one clock cycle per accepted condition.
- R8: With `fast_sel` = 1 the lines are sampled every clock cycle. With `fast_sel` = 0 they are sampled every second cycle, so every window is counted in those ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fast_sel | input | 1 | 1: sample every clock; 0: sample every second clock |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line, asynchronous |
| irq_pulse | output | 1 | One-cycle pulse per accepted condition |
| bus_busy | output | 1 | 1 after an opening condition, 0 after a closing one |

## Verification
The assertions assume that `fast_sel` holds steady while a window is being counted. They also assume that SCL and SDA each go through the synchronizer as single clean levels, so both lines reach the qualifier with the same latency. The stimulus changes `fast_sel` only while SCL is low and idle for several ticks. It holds every line level for a whole number of sampling periods, so each segment covers an exact number of ticks whatever the tick phase. The sweep covers setup and hold lengths from one tick up to two past the threshold, in both directions and at both sampling rates. It also sends SDA toggles while SCL is low.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
    typedef enum logic {
        QS_IDLE = 1'b0,
        QS_HOLD = 1'b1
    } qual_state_e;
endpackage

// File: rtl/bcd_sync.sv
module bcd_sync #(
    parameter int WIDTH   = 2,
    parameter int STAGES  = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [STAGES-1:0] chain_d, chain_q;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_i[b]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else        chain_q <= chain_d;
        end

        assign sync_o[b] = chain_q[STAGES-1];
    end
endmodule

// File: rtl/bcd_tick.sv
module bcd_tick (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    output logic tick_o
);
    logic phase_d, phase_q;

    always_comb begin
        phase_d = ~phase_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) phase_q <= 1'b0;
        else        phase_q <= phase_d;
    end

    assign tick_o = fast_sel | phase_q;
endmodule

// File: rtl/bcd_qualifier.sv
module bcd_qualifier
    import bcd_pkg::*;
#(
    parameter int THRESH = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic scl_i,
    input  logic sda_i,
    output logic irq_o,
    output logic busy_o
);
    localparam int         CW      = $clog2(THRESH + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(THRESH);
    localparam logic [CW-1:0] CNT_ONE = CW'(1);
    localparam bit         INSTANT = (THRESH <= 1);

    typedef struct packed {
        qual_state_e   st;
        logic          open_dir;
        logic [CW-1:0] cnt;
        logic          scl_prev;
        logic          sda_prev;
        logic          irq;
        logic          busy;
    } qual_regs_t;

    qual_regs_t cur_q, nxt_d;
    logic       stable, sda_edge;

    always_comb begin
        nxt_d    = cur_q;
        nxt_d.irq = 1'b0;
        stable   = scl_i && cur_q.scl_prev && (sda_i == cur_q.sda_prev);
        sda_edge = scl_i && cur_q.scl_prev && (sda_i != cur_q.sda_prev);

        if (tick_i) begin
            nxt_d.scl_prev = scl_i;
            nxt_d.sda_prev = sda_i;

            if (!scl_i)                nxt_d.cnt = '0;
            else if (!stable)          nxt_d.cnt = CNT_ONE;
            else if (cur_q.cnt != CNT_MAX) nxt_d.cnt = cur_q.cnt + CNT_ONE;

            unique case (cur_q.st)
                QS_IDLE: begin
                    if (sda_edge && (cur_q.cnt >= CNT_MAX)) begin
                        if (INSTANT) begin
                            nxt_d.irq  = 1'b1;
                            nxt_d.busy = ~sda_i;
                        end else begin
                            nxt_d.st       = QS_HOLD;
                            nxt_d.open_dir = ~sda_i;
                        end
                    end
                end
                QS_HOLD: begin
                    if (!stable) begin
                        nxt_d.st = QS_IDLE;
                    end else if (nxt_d.cnt >= CNT_MAX) begin
                        nxt_d.irq  = 1'b1;
                        nxt_d.busy = cur_q.open_dir;
                        nxt_d.st   = QS_IDLE;
                    end
                end
                default: nxt_d.st = QS_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{st: QS_IDLE, open_dir: 1'b0, cnt: '0, scl_prev: 1'b0,
                       sda_prev: 1'b0, irq: 1'b0, busy: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign irq_o  = cur_q.irq;
    assign busy_o = cur_q.busy;
endmodule

// File: rtl/bus_cond_detector.sv
module bus_cond_detector #(
    parameter int THRESH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fast_sel,
    input  logic scl_in,
    input  logic sda_in,
    output logic irq_pulse,
    output logic bus_busy
);
    logic [1:0] lines_s;
    logic       scl_s, sda_s, tick;

    bcd_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(1'b1)) sync_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({scl_in, sda_in}),
        .sync_o  (lines_s)
    );

    assign scl_s = lines_s[1];
    assign sda_s = lines_s[0];

    bcd_tick tick_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .fast_sel (fast_sel),
        .tick_o   (tick)
    );

    bcd_qualifier #(.THRESH(THRESH)) qual_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .scl_i  (scl_s),
        .sda_i  (sda_s),
        .irq_o  (irq_pulse),
        .busy_o (bus_busy)
    );
endmodule

// File: rtl/bcd_checker.sv
module bcd_checker (
    input logic clk,
    input logic rst_n,
    input logic fast_sel,
    input logic tick,
    input logic scl_s,
    input logic irq,
    input logic busy
);
    always_comb begin
        if (!rst_n) begin
            p_reset_quiet_r1: assert (!irq && !busy);
        end
    end

    p_open_pulses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> irq);

    p_close_pulses_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> irq);

    p_scl_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(scl_s));

    p_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_fast_every_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fast_sel |-> tick);

    p_slow_alternate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !fast_sel) |=> (!tick || fast_sel));

    p_irq_on_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(tick));
endmodule

bind bus_cond_detector bcd_checker chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .fast_sel (fast_sel),
    .tick     (tick),
    .scl_s    (scl_s),
    .irq      (irq_pulse),
    .busy     (bus_busy)
);

// File: tb/bus_cond_detector_tb.sv
`timescale 1ns/1ps
module bus_cond_detector_tb_top;
    localparam int T = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic fast_sel = 1'b1;
    logic scl_in = 1'b1;
    logic sda_in = 1'b1;
    logic irq_pulse, bus_busy;

    int checks = 0;
    int failures = 0;
    int irq_count = 0;
    bit irq_prev = 1'b0;
    bit wide_seen = 1'b0;
    bit exp_busy = 1'b0;

    always #10 clk = ~clk;

    bus_cond_detector #(.THRESH(T)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .fast_sel  (fast_sel),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .irq_pulse (irq_pulse),
        .bus_busy  (bus_busy)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (irq_pulse) irq_count++;
            if (irq_pulse && irq_prev) wide_seen = 1'b1;
        end
        irq_prev = irq_pulse;
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        int div;
        div = fast_sel ? 1 : 2;
        repeat (n * div) @(negedge clk);
    endtask

    task automatic run_case(input bit fs, input bit open_c, input int s, input int h);
        int base;
        bit acc;
        fast_sel = fs;
        scl_in = 1'b0;
        wait_ticks(3);
        sda_in = open_c ? 1'b1 : 1'b0;
        wait_ticks(3);
        base = irq_count;
        scl_in = 1'b1;
        wait_ticks(s);
        sda_in = ~sda_in;
        wait_ticks(h);
        scl_in = 1'b0;
        wait_ticks(3);
        repeat (6) @(negedge clk);
        acc = (s >= T) && (h >= T);
        if (acc) exp_busy = open_c;
        if (open_c) begin
            if (s < T)      check("R4 open setup", irq_count - base, 0);
            else if (h < T) check("R5 open hold", irq_count - base, 0);
            else            check("R2 open pulse", irq_count - base, 1);
            check("R2 busy", bus_busy, exp_busy);
        end else begin
            if (s < T)      check("R4 close setup", irq_count - base, 0);
            else if (h < T) check("R5 close hold", irq_count - base, 0);
            else            check("R3 close pulse", irq_count - base, 1);
            check("R3 busy", bus_busy, exp_busy);
        end
    endtask

    initial begin
        int base;
        repeat (3) @(negedge clk);
        check("R1 irq in reset", irq_pulse, 0);
        check("R1 busy in reset", bus_busy, 0);
        rst_n = 1'b1;
        repeat (8) @(negedge clk);
        check("R1 irq after reset", irq_count, 0);
        check("R1 busy after reset", bus_busy, 0);

        for (int fs = 1; fs >= 0; fs--) begin
            for (int s = 1; s <= T + 2; s++) begin
                for (int h = 1; h <= T + 2; h++) begin
                    for (int d = 1; d >= 0; d--) begin
                        run_case(fs[0], d[0], s, h);
                    end
                end
            end
        end

        run_case(1'b0, 1'b1, T, T);
        run_case(1'b0, 1'b1, T + 1, T + 1);
        check("R2 repeated open busy", bus_busy, 1);

        base = irq_count;
        fast_sel = 1'b1;
        scl_in = 1'b0;
        wait_ticks(3);
        for (int i = 0; i < 10; i++) begin
            sda_in = ~sda_in;
            wait_ticks(T + 2);
        end
        repeat (6) @(negedge clk);
        check("R6 toggles with scl low", irq_count - base, 0);
        check("R6 busy unchanged", bus_busy, 1);

        check("R7 pulse width", wide_seen, 0);
        check("R8 slow-rate sweep accepted count", irq_count > 0, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule